// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block is a small bank of 32-bit registers that sits on a simple memory-mapped bus and drives the static control pins of a receive PHY. Each write carries its own per-bit enables: the upper half-word of the write data selects which bits of the lower half-word are updated. Software can therefore change a single field (one lane's enable, the test clock pin) with one write and no read-modify-write. Bits whose enable is clear keep their stored value.

Three control words hold the per-lane controls, the serial test-port pins and the per-lane turnaround requests. A fourth, read-only word returns the PHY's 8-bit test data output. Reads are requested with a single-cycle strobe and answered one cycle later. The read port is a two-state machine. It sits in RD_IDLE when no read is pending and moves to RD_DONE on any cycle with `rd_en` high. It stays in RD_DONE while `rd_en` stays high and returns to RD_IDLE when `rd_en` is low. `rd_valid` is high exactly in RD_DONE.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: On a write to a control word, data bit n (n in 0..15) takes `wr_data[n]` when `wr_data[n+16]` is 1; the update is visible on the outputs on the clock edge that accepts the write.
- R2: On a write to a control word, every data bit whose mask bit `wr_data[n+16]` is 0 keeps its previous value; a write with an all-zero mask changes nothing.
- R3: Word 0 holds the lane controls: lane enable at [3:0], force receive mode at [7:4], force transmit-stop mode at [11:8], turnaround disable at [15:12].
- R4: Word 1 holds the test port: test data input at [7:0], test enable at bit 8, test clock at bit 9, test clear at bit 10; bits [15:11] are stored and read back but drive no pin.
- R5: Word 2 holds the turnaround request at [3:0]; bits [15:4] are stored and read back but drive no pin.
- R6: Word 3 is read-only: a read returns `{24'b0, test_dout_i}` as sampled in the read cycle, and a write to it changes no output and no stored bit.
- R7: A read strobe on `rd_en` gives `rd_valid` high in the next cycle. A read of a control word then shows its stored 16 bits on `rd_data`, and the upper 16 bits read as zero. `rd_data` is zero whenever `rd_valid` is low.
- R8: After reset every control bit is 0 except the test clock (word 1, bit 9), which is 1, so word 1 reads 0x0200.
- R9: Addresses 4 to 15 are unmapped: a write there changes no output and no stored bit, and a read returns zero with `rd_valid` high.
- R10: A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 4 | Word index |
| wr_data | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| test_dout_i | input | 8 | Test data output from the PHY |
| rd_data | output | 32 | Read response, valid with rd_valid |
| rd_valid | output | 1 | Read response valid |
| lane_en_o | output | 4 | Per-lane enable |
| force_rx_o | output | 4 | Per-lane force receive mode |
| force_stop_o | output | 4 | Per-lane force transmit-stop mode |
| turn_dis_o | output | 4 | Per-lane turnaround disable |
| turn_req_o | output | 4 | Per-lane turnaround request |
| test_din_o | output | 8 | Test data input to the PHY |
| test_en_o | output | 1 | Test enable |
| test_clk_o | output | 1 | Test clock, idle high |
| test_clr_o | output | 1 | Test clear |

## Verification
Every stored bit drives a pin or comes back on a read, so a corrupted register bit shows on the next read of its word. A bit that drives a pin shows on that pin in the very cycle after the faulty write. A mask applied to the wrong half, or an enable bit that is off by one, makes a partial-mask write either leave an enabled bit stale or disturb a neighbouring field. Both show on the pins one cycle after the write. A wrong read state shows as `rd_valid` or a non-zero idle `rd_data` one cycle after the strobe.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int BUS_W    = 32;
    localparam int HALF_W   = BUS_W / 2;
    localparam int LANES    = 4;
    localparam int TDATA_W  = 8;
    localparam int NUM_CTRL = 3;

    // word indices
    localparam int OFF_LANE = 0;
    localparam int OFF_TEST = 1;
    localparam int OFF_TURN = 2;
    localparam int OFF_STAT = 3;

    // bit positions inside the test word
    localparam int TEN_BIT  = TDATA_W;
    localparam int TCLK_BIT = TDATA_W + 1;
    localparam int TCLR_BIT = TDATA_W + 2;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_DONE = 1'b1
    } rd_state_e;

    // reset image of each control word: test clock idles high
    function automatic logic [HALF_W-1:0] ctrl_reset(input int idx);
        return (idx == OFF_TEST) ? (HALF_W'(1) << TCLK_BIT) : '0;
    endfunction
endpackage

// File: rtl/hwm_mreg.sv
module hwm_mreg #(
    parameter int             W   = 16,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else if (we) begin
            q <= (q & ~wmask) | (wdata & wmask);
        end
    end
endmodule

// File: rtl/hwm_decode.sv
module hwm_decode #(
    parameter int ADDR_W   = 4,
    parameter int NUM_CTRL = 3,
    parameter int STAT_OFF = 3
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] sel,
    output logic                stat_hit
);
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
    assign stat_hit = (addr == ADDR_W'(STAT_OFF));
endmodule

// File: rtl/hwm_rdmux.sv
module hwm_rdmux #(
    parameter int NUM_CTRL = 3,
    parameter int HALF_W   = 16,
    parameter int BUS_W    = 32,
    parameter int TD_W     = 8
) (
    input  logic [NUM_CTRL-1:0]        sel,
    input  logic                       stat_hit,
    input  logic [NUM_CTRL*HALF_W-1:0] regs_flat,
    input  logic [TD_W-1:0]            status,
    output logic [BUS_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (sel[i]) rdata = BUS_W'(regs_flat[i*HALF_W +: HALF_W]);
        end
        if (stat_hit) rdata = BUS_W'(status);
    end
endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
    import hwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [TDATA_W-1:0] test_dout_i,
    output logic [BUS_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic [LANES-1:0]   lane_en_o,
    output logic [LANES-1:0]   force_rx_o,
    output logic [LANES-1:0]   force_stop_o,
    output logic [LANES-1:0]   turn_dis_o,
    output logic [LANES-1:0]   turn_req_o,
    output logic [TDATA_W-1:0] test_din_o,
    output logic               test_en_o,
    output logic               test_clk_o,
    output logic               test_clr_o
);
    localparam int LANE_BASE = OFF_LANE * HALF_W;
    localparam int TEST_BASE = OFF_TEST * HALF_W;
    localparam int TURN_BASE = OFF_TURN * HALF_W;

    logic [NUM_CTRL-1:0]        sel;
    logic                       stat_hit;
    logic [NUM_CTRL*HALF_W-1:0] regs_flat;
    logic [BUS_W-1:0]           rdata_c;
    logic [HALF_W-1:0]          wmask;
    logic [HALF_W-1:0]          wval;

    rd_state_e rd_state, rd_state_nxt;

    assign wmask = wr_data[BUS_W-1:HALF_W];
    assign wval  = wr_data[HALF_W-1:0];

    hwm_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CTRL (NUM_CTRL),
        .STAT_OFF (OFF_STAT)
    ) u_dec (
        .addr     (addr),
        .sel      (sel),
        .stat_hit (stat_hit)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
        hwm_mreg #(
            .W   (HALF_W),
            .RST (ctrl_reset(i))
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && sel[i]),
            .wdata (wval),
            .wmask (wmask),
            .q     (regs_flat[i*HALF_W +: HALF_W])
        );
    end

    hwm_rdmux #(
        .NUM_CTRL (NUM_CTRL),
        .HALF_W   (HALF_W),
        .BUS_W    (BUS_W),
        .TD_W     (TDATA_W)
    ) u_rmux (
        .sel       (sel),
        .stat_hit  (stat_hit),
        .regs_flat (regs_flat),
        .status    (test_dout_i),
        .rdata     (rdata_c)
    );

    // read port: next-state logic
    always_comb begin
        unique case (rd_state)
            RD_IDLE: rd_state_nxt = rd_en ? RD_DONE : RD_IDLE;
            RD_DONE: rd_state_nxt = rd_en ? RD_DONE : RD_IDLE;
            default: rd_state_nxt = RD_IDLE;
        endcase
    end

    // read port: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_state <= RD_IDLE;
        else        rd_state <= rd_state_nxt;
    end

    // read port: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? rdata_c : '0;
    end
    assign rd_valid = (rd_state == RD_DONE);

    // pin fan-out
    assign lane_en_o    = regs_flat[LANE_BASE + 0*LANES +: LANES];
    assign force_rx_o   = regs_flat[LANE_BASE + 1*LANES +: LANES];
    assign force_stop_o = regs_flat[LANE_BASE + 2*LANES +: LANES];
    assign turn_dis_o   = regs_flat[LANE_BASE + 3*LANES +: LANES];
    assign turn_req_o   = regs_flat[TURN_BASE +: LANES];
    assign test_din_o   = regs_flat[TEST_BASE +: TDATA_W];
    assign test_en_o    = regs_flat[TEST_BASE + TEN_BIT];
    assign test_clk_o   = regs_flat[TEST_BASE + TCLK_BIT];
    assign test_clr_o   = regs_flat[TEST_BASE + TCLR_BIT];
endmodule

// File: rtl/hwm_ctrl_bank_chk.sv
module hwm_ctrl_bank_chk
    import hwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [BUS_W-1:0]   wr_data,
    input logic [BUS_W-1:0]   rd_data,
    input logic               rd_valid,
    input logic [LANES-1:0]   lane_en_o,
    input logic [LANES-1:0]   force_rx_o,
    input logic [LANES-1:0]   force_stop_o,
    input logic [LANES-1:0]   turn_dis_o,
    input logic [LANES-1:0]   turn_req_o,
    input logic [TDATA_W-1:0] test_din_o,
    input logic               test_en_o,
    input logic               test_clk_o,
    input logic               test_clr_o
);
    localparam logic [ADDR_W-1:0] A_LANE = ADDR_W'(OFF_LANE);
    localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(OFF_TEST);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam int TV_W = TDATA_W + 3;

    logic [HALF_W-1:0] lane_vec;
    logic [TV_W-1:0]   test_vec;

    assign lane_vec = {turn_dis_o, force_stop_o, force_rx_o, lane_en_o};
    assign test_vec = {test_clr_o, test_clk_o, test_en_o, test_din_o};

    // R1, R3: enabled bits of the lane word follow the written data
    p_lane_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LANE) |=>
        (((lane_vec ^ $past(wr_data[HALF_W-1:0])) & $past(wr_data[BUS_W-1:HALF_W])) == '0));

    // R2: masked-off bits of the lane word hold
    p_lane_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LANE) |=>
        (((lane_vec ^ $past(lane_vec)) & ~$past(wr_data[BUS_W-1:HALF_W])) == '0));

    // R4: enabled test-port bits follow the written data
    p_test_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TEST) |=>
        (((test_vec ^ $past(wr_data[TV_W-1:0])) & $past(wr_data[HALF_W+TV_W-1:HALF_W])) == '0));

    // R6: writes to the status word touch nothing
    p_stat_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT) |=>
        ($stable(lane_vec) && $stable(test_vec) && $stable(turn_req_o)));

    // R9: writes to unmapped words touch nothing
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > A_STAT) |=>
        ($stable(lane_vec) && $stable(test_vec) && $stable(turn_req_o)));

    // R7: response timing and data shape
    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_rd_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[BUS_W-1:HALF_W] == '0));
    p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
endmodule

bind hwm_ctrl_bank hwm_ctrl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .lane_en_o    (lane_en_o),
    .force_rx_o   (force_rx_o),
    .force_stop_o (force_stop_o),
    .turn_dis_o   (turn_dis_o),
    .turn_req_o   (turn_req_o),
    .test_din_o   (test_din_o),
    .test_en_o    (test_en_o),
    .test_clk_o   (test_clk_o),
    .test_clr_o   (test_clr_o)
);

// File: tb/sim_hwm_ctrl_bank.sv
module sim_hwm_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  test_dout_i = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  lane_en_o, force_rx_o, force_stop_o, turn_dis_o, turn_req_o;
    logic [7:0]  test_din_o;
    logic        test_en_o, test_clk_o, test_clr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] m [3];

    always #4 clk = ~clk;

    hwm_ctrl_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .test_dout_i(test_dout_i), .rd_data(rd_data),
        .rd_valid(rd_valid), .lane_en_o(lane_en_o), .force_rx_o(force_rx_o),
        .force_stop_o(force_stop_o), .turn_dis_o(turn_dis_o),
        .turn_req_o(turn_req_o), .test_din_o(test_din_o), .test_en_o(test_en_o),
        .test_clk_o(test_clk_o), .test_clr_o(test_clr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // pins against the model words (R3, R4, R5 layouts)
    task automatic cmp_pins(input string tag);
        chk({tag, " R3 lane pins"},
            {16'h0, turn_dis_o, force_stop_o, force_rx_o, lane_en_o}, {16'h0, m[0]});
        chk({tag, " R4 test pins"},
            {21'h0, test_clr_o, test_clk_o, test_en_o, test_din_o}, {21'h0, m[1][10:0]});
        chk({tag, " R5 turn pins"}, {28'h0, turn_req_o}, {28'h0, m[2][3:0]});
    endtask

    task automatic step(input bit we, input bit re, input logic [3:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        wr_en = we; rd_en = re; addr = a; wr_data = d;
        @(posedge clk);
        if (a < 4'd3)       exp_rd = {16'h0, m[a]};
        else if (a == 4'd3) exp_rd = {24'h0, test_dout_i};
        else                exp_rd = '0;
        if (we && a < 4'd3) m[a] = (m[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk({tag, " R7 rd_valid"}, {31'h0, rd_valid}, {31'h0, re});
        if (re) chk({tag, " rd_data"}, rd_data, exp_rd);
        else    chk({tag, " R7 idle rd_data"}, rd_data, '0);
        cmp_pins(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m[0] = 16'h0000; m[1] = 16'h0200; m[2] = 16'h0000;
        repeat (3) @(negedge clk);
        cmp_pins("R8 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_pins("R8 after reset");
        step(0, 1, 4'd1, '0, "R8 read test word");
        step(0, 1, 4'd0, '0, "R8 read lane word");

        step(1, 0, 4'd0, 32'hFFFF_A5C3, "R1 R3 full lane write");
        step(1, 1, 4'd0, 32'h00F0_0000, "R2 clear force_rx only");
        step(0, 1, 4'd0, '0, "R7 R2 lane readback");
        step(1, 0, 4'd0, 32'h0000_FFFF, "R2 zero mask");
        step(1, 0, 4'd0, 32'h8001_0000, "R1 single bits");

        step(1, 0, 4'd1, 32'hFFFF_075A, "R4 test word write");
        step(1, 0, 4'd1, 32'h0200_0000, "R4 drop test clock");
        step(1, 0, 4'd1, 32'hF800_F800, "R4 spare bits");
        step(0, 1, 4'd1, '0, "R4 R7 test readback");

        step(1, 0, 4'd2, 32'hFFFF_ABC9, "R5 turn write");
        step(0, 1, 4'd2, '0, "R5 turn readback");

        test_dout_i = 8'h3C;
        step(1, 0, 4'd3, 32'hFFFF_FFFF, "R6 status write ignored");
        step(0, 1, 4'd3, '0, "R6 status read");
        test_dout_i = 8'hC3;
        step(0, 1, 4'd3, '0, "R6 status read new");

        step(1, 0, 4'd7,  32'hFFFF_FFFF, "R9 unmapped write 7");
        step(1, 0, 4'd15, 32'hFFFF_FFFF, "R9 unmapped write 15");
        step(0, 1, 4'd9, '0, "R9 unmapped read");
        for (int k = 0; k < 3; k++) step(0, 1, 4'(k), '0, "R9 words untouched");

        step(1, 1, 4'd2, 32'hFFFF_1234, "R10 read with write");
        step(0, 1, 4'd2, '0, "R10 after write");

        for (int k = 0; k < 400; k++) begin
            test_dout_i = 8'($urandom);
            step(1'($urandom), 1'($urandom), 4'($urandom), $urandom, "R1 R2 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule